// File: doc/BRIEF.md
# Asynchronous Serial Transceiver Core

This block is a byte-wide asynchronous serial transmitter and receiver behind a small register interface. Software writes a byte into a one-entry holding buffer; when transmission is enabled and the shifter is idle, the byte moves into the shifter. The shifter sends a start bit, the data bits least significant first, and a stop bit. The receiver watches the incoming line. It confirms a start bit at the middle of the bit and samples every later bit at its middle. It then places the byte in a one-entry receive buffer.

Both directions are paced by a single-cycle oversampling tick from an external baud generator. OSR ticks make one bit time. Status shows two separate conditions on the transmit side: holding buffer empty and shifter empty. It also shows receive-buffer-full and the receive error conditions. A mask register selects which flags drive a single registered interrupt line. Reading the received byte clears the full flag and all receive errors. A second view of the error flags can be cleared selectively by a write.

Top module: `async_serial_core`

## Requirements
- R1: After reset, control reads 0x00, status reads 0x03, the mask reads 0x00, the error view reads 0x00, irq is 0 and txd is 1.
- R2: The control register is at address 0. Bit 0 enables transmit and bit 1 enables receive; both read back as written. Writing bit 2 as 1 empties the holding buffer, and bit 2 always reads 0.
- R3: A transmitted frame is: one low start bit, then DATA_BITS data bits with the least significant bit first, then one high stop bit. Each bit lasts OSR ticks. txd is high whenever no frame is being sent.
- R4: Status is at address 1. Bit 0 is set while the holding buffer is empty. Bit 1 is set while the shifter is idle. A transmission is finished only when both bits read 1.
- R5: The receiver starts a frame on a low line at a tick. It drops the frame if the line is high again at the middle of the start bit. Data bits are sampled at mid-bit. A completed byte is read from address 4 and sets status bit 2.
- R6: A low stop-bit sample sets framing error, status bit 4. The byte is still stored.
- R7: A byte that completes while status bit 2 is set is discarded, and overrun (status bit 5) is set. The earlier byte is kept.
- R8: Status bit 6 is the OR of bits 3, 4 and 5. Bit 3 (parity error) always reads 0 because frames carry no parity.
- R9: Reading the data register at address 4 clears status bits 2, 4 and 5.
- R10: Address 2 shows the same four error flags at bits 6..3. A write to address 2 clears each error flag whose bit in the written value is 0.
- R11: The mask at address 3 keeps only bits 0, 1, 2 and 6; the other bits read 0. Each kept bit enables the status flag at the same position. irq is the registered OR of the enabled flags, so it lags the flags by one cycle.
- R12: While transmit is disabled, a held byte is not sent. While receive is disabled, the line is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling strobe, OSR per bit |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the core with its defaults, DATA_BITS = 8 and OSR = 16, and runs the tick at every second clock. With eight data bits, all 256 byte values can be sent through a transmit-to-receive loopback. Each byte is checked on arrival. The short frame also leaves room for directed cases: a bit-level trace of the transmit waveform, a start glitch, a bad stop bit, an overrun, and mask and interrupt timing.

// File: rtl/async_serial_core.sv
module async_serial_core #(
  parameter int DATA_BITS = 8,
  parameter int OSR       = 16,
  parameter int REG_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [2:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             txd,
  input  logic             rxd,
  output logic             irq
);
  localparam int CW    = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int FRAME = DATA_BITS + 2;
  localparam int BW    = $clog2(FRAME + 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_ERR = 3'd2, A_MASK = 3'd3, A_DATA = 3'd4;
  localparam logic [6:0] MASK_KEEP = 7'b1000111;
  localparam logic [6:0] ERR_BITS  = 7'b1111000;

  logic tx_en, rx_en;
  logic [DATA_BITS-1:0] hold;
  logic hold_full;
  logic [FRAME-1:0] tsh;
  logic tbusy;
  logic [CW-1:0] tcnt;
  logic [BW-1:0] tidx;

  logic rs1, rs2, rbusy;
  logic [CW-1:0] rcnt;
  logic [BW-1:0] ridx;
  logic [DATA_BITS-1:0] rsh, rbuf;
  logic rx_full, ov, fe;
  logic [6:0] mask;
  logic [6:0] stat;

  wire wr_ctrl = reg_wr && reg_addr == A_CTRL;
  wire wr_err  = reg_wr && reg_addr == A_ERR;
  wire wr_mask = reg_wr && reg_addr == A_MASK;
  wire wr_data = reg_wr && reg_addr == A_DATA;
  wire rd_data = reg_rd && reg_addr == A_DATA;
  wire tx_clr  = wr_ctrl && reg_wdata[2];
  wire tx_load = tx_en && hold_full && !tbusy && !wr_data && !tx_clr;
  wire rx_mid  = rx_en && rbusy && tick && rcnt == MID;
  wire rx_done = rx_mid && ridx == BW'(FRAME - 1);
  wire full_eff = rx_full && !rd_data;

  assign stat = {fe | ov, ov, fe, 1'b0, rx_full, !tbusy, !hold_full};
  assign txd  = tbusy ? tsh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en <= 1'b0;
      rx_en <= 1'b0;
      mask  <= '0;
      irq   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        tx_en <= reg_wdata[0];
        rx_en <= reg_wdata[1];
      end
      if (wr_mask) mask <= reg_wdata[6:0] & MASK_KEEP;
      irq <= |(stat & mask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      hold_full <= 1'b0;
      tsh       <= '1;
      tbusy     <= 1'b0;
      tcnt      <= '0;
      tidx      <= '0;
    end else begin
      if (wr_data) begin
        hold      <= reg_wdata[DATA_BITS-1:0];
        hold_full <= 1'b1;
      end else if (tx_clr) begin
        hold_full <= 1'b0;
      end else if (tx_load) begin
        hold_full <= 1'b0;
      end
      if (tx_load) begin
        tsh   <= {1'b1, hold, 1'b0};
        tbusy <= 1'b1;
        tcnt  <= '0;
        tidx  <= '0;
      end else if (tbusy && tick) begin
        tcnt <= (tcnt == LAST) ? '0 : tcnt + 1'b1;
        if (tcnt == LAST) begin
          tsh  <= {1'b1, tsh[FRAME-1:1]};
          tidx <= tidx + 1'b1;
          if (tidx == BW'(FRAME - 1)) tbusy <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1   <= 1'b1;
      rs2   <= 1'b1;
      rbusy <= 1'b0;
      rcnt  <= '0;
      ridx  <= '0;
      rsh   <= '0;
    end else begin
      rs1 <= rxd;
      rs2 <= rs1;
      if (!rx_en) begin
        rbusy <= 1'b0;
      end else if (!rbusy) begin
        if (tick && !rs2) begin
          rbusy <= 1'b1;
          rcnt  <= '0;
          ridx  <= '0;
        end
      end else if (tick) begin
        rcnt <= (rcnt == LAST) ? '0 : rcnt + 1'b1;
        if (rx_mid) begin
          if ((ridx == '0 && rs2) || ridx == BW'(FRAME - 1)) begin
            rbusy <= 1'b0;
          end else begin
            ridx <= ridx + 1'b1;
            if (ridx != '0) rsh <= {rs2, rsh[DATA_BITS-1:1]};
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbuf    <= '0;
      rx_full <= 1'b0;
      ov      <= 1'b0;
      fe      <= 1'b0;
    end else begin
      if (rd_data) begin
        rx_full <= 1'b0;
        ov      <= 1'b0;
        fe      <= 1'b0;
      end
      if (wr_err) begin
        ov <= ov & reg_wdata[5];
        fe <= fe & reg_wdata[4];
      end
      if (rx_done) begin
        if (full_eff) begin
          ov <= 1'b1;
        end else begin
          rbuf    <= rsh;
          rx_full <= 1'b1;
          if (!rs2) fe <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = REG_W'({rx_en, tx_en});
      A_STAT:  reg_rdata = REG_W'(stat);
      A_ERR:   reg_rdata = REG_W'(stat & ERR_BITS);
      A_MASK:  reg_rdata = REG_W'(mask);
      A_DATA:  reg_rdata = REG_W'(rbuf);
      default: reg_rdata = '0;
    endcase
  end
endmodule

module async_serial_core_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 txd,
  input logic                 tbusy,
  input logic                 hold_full,
  input logic                 tx_clr,
  input logic                 rx_full,
  input logic                 ov,
  input logic                 rd_data,
  input logic [DATA_BITS-1:0] rbuf,
  input logic [6:0]           mask,
  input logic                 irq
);
  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(tbusy) |-> !txd);
  // R2
  clear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_clr |=> !hold_full);
  // R7
  ovr_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(ov) |-> $past(rx_full));
  // R7
  keep_byte_chk: assert property (@(posedge clk) disable iff (!rst_n) (rx_full && !rd_data) |=> $stable(rbuf));
  // R9
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_data |=> !ov);
  // R11
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> $past(mask != 7'd0));
endmodule

bind async_serial_core async_serial_core_chk #(.DATA_BITS(DATA_BITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .txd(txd), .tbusy(tbusy), .hold_full(hold_full),
  .tx_clr(tx_clr), .rx_full(rx_full), .ov(ov), .rd_data(rd_data), .rbuf(rbuf),
  .mask(mask), .irq(irq)
);

// File: tb/async_serial_core_tb.sv
module async_serial_core_tb_top;
  localparam int BITCLK = 32;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic txd, irq;
  logic loop = 1'b0, rxb = 1'b1;
  wire rxd = loop ? txd : rxb;
  int total = 0, bad = 0;
  logic [7:0] v;

  always #2 clk = ~clk;

  async_serial_core dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .txd(txd),
    .rxd(rxd), .irq(irq)
  );

  initial forever begin
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_stat(input logic [7:0] m, input logic [7:0] want, output bit ok);
    logic [7:0] s;
    ok = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      peek(3'd1, s);
      if ((s & m) == want) begin ok = 1'b1; break; end
    end
  endtask

  task automatic send(input logic [7:0] b, input logic stopv);
    @(negedge clk);
    rxb = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxb = b[i];
      repeat (BITCLK) @(negedge clk);
    end
    rxb = stopv;
    repeat (BITCLK) @(negedge clk);
    rxb = 1'b1;
    repeat (BITCLK) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    peek(3'd0, v); chk(v == 8'h00, "R1 ctrl", v, 8'h00);
    peek(3'd1, v); chk(v == 8'h03, "R1 status", v, 8'h03);
    peek(3'd3, v); chk(v == 8'h00, "R1 mask", v, 8'h00);
    peek(3'd2, v); chk(v == 8'h00, "R1 errview", v, 8'h00);
    chk(irq == 1'b0 && txd == 1'b1, "R1 irq/txd", {irq, txd}, 2'b01);

    // R2 control readback, tx clear bit reads 0
    wr(3'd0, 8'h07); peek(3'd0, v); chk(v == 8'h03, "R2 ctrl readback", v, 8'h03);

    // R12 transmit disabled keeps the byte held
    wr(3'd0, 8'h00);
    wr(3'd4, 8'h5E);
    ok = 1'b1;
    for (int i = 0; i < 400; i++) begin @(negedge clk); if (!txd) ok = 1'b0; end
    chk(ok, "R12 tx disabled line idle", ok, 1);
    peek(3'd1, v); chk(v[1:0] == 2'b10, "R12 held byte", v[1:0], 2'b10);
    // R2 tx clear empties holding buffer
    wr(3'd0, 8'h04);
    peek(3'd1, v); chk(v[1:0] == 2'b11, "R2 tx clear", v[1:0], 2'b11);
    wr(3'd0, 8'h01);
    repeat (400) @(negedge clk);
    chk(txd == 1'b1, "R2 cleared byte not sent", txd, 1);

    // R4 separate empty flags
    wr(3'd4, 8'h11);
    @(negedge clk);
    peek(3'd1, v); chk(v[1:0] == 2'b01, "R4 buffer empty shifter busy", v[1:0], 2'b01);
    wr(3'd4, 8'h22);
    peek(3'd1, v); chk(v[1:0] == 2'b00, "R4 both busy", v[1:0], 2'b00);
    wait_stat(8'h03, 8'h03, ok); chk(ok, "R4 completion both set", ok, 1);

    // R12 receive disabled ignores line
    send(8'h3C, 1'b1);
    peek(3'd1, v); chk(v[2] == 1'b0, "R12 rx disabled", v[2], 0);

    // R3 transmit waveform
    wr(3'd4, 8'hA5);
    wait (txd == 1'b0);
    repeat (BITCLK / 2) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      logic e;
      e = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : v[0];
      e = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : 8'hA5 >> (i - 1);
      chk(txd == e, "R3 tx bit", txd, e);
      repeat (BITCLK) @(negedge clk);
    end

    // R5 start glitch rejected
    wr(3'd0, 8'h02);
    @(negedge clk); rxb = 1'b0;
    repeat (4) @(negedge clk); rxb = 1'b1;
    repeat (12 * BITCLK) @(negedge clk);
    peek(3'd1, v); chk(v == 8'h03, "R5 glitch ignored", v, 8'h03);

    // R7 R8 overrun
    send(8'h3C, 1'b1);
    send(8'h99, 1'b1);
    peek(3'd1, v); chk(v == 8'h67, "R7 R8 overrun status", v, 8'h67);
    rd(3'd4, v); chk(v == 8'h3C, "R7 first byte kept", v, 8'h3C);
    peek(3'd1, v); chk(v == 8'h03, "R9 read clears", v, 8'h03);

    // R6 R10 framing error
    send(8'h5A, 1'b0);
    peek(3'd1, v); chk(v == 8'h57, "R6 R8 framing status", v, 8'h57);
    peek(3'd2, v); chk(v == 8'h50, "R10 error view", v, 8'h50);
    wr(3'd2, 8'hEF);
    peek(3'd2, v); chk(v == 8'h00, "R10 selective clear", v, 8'h00);
    peek(3'd1, v); chk(v == 8'h07, "R10 full kept", v, 8'h07);
    rd(3'd4, v); chk(v == 8'h5A, "R6 byte stored", v, 8'h5A);

    // R11 mask and irq
    wr(3'd3, 8'hFF); peek(3'd3, v); chk(v == 8'h47, "R11 mask bits", v, 8'h47);
    wr(3'd3, 8'h04);
    @(negedge clk); chk(irq == 1'b0, "R11 irq masked idle", irq, 0);
    send(8'h81, 1'b1);
    chk(irq == 1'b1, "R11 irq on full", irq, 1);
    rd(3'd4, v);
    @(negedge clk); chk(irq == 1'b0, "R11 irq drops", irq, 0);
    wr(3'd3, 8'h01);
    @(negedge clk); chk(irq == 1'b1, "R11 irq tbe", irq, 1);
    wr(3'd3, 8'h00);

    // R5 exhaustive loopback sweep
    loop = 1'b1;
    wr(3'd0, 8'h03);
    for (int b = 0; b < 256; b++) begin
      wr(3'd4, 8'(b));
      wait_stat(8'h04, 8'h04, ok);
      rd(3'd4, v);
      chk(ok && v == 8'(b), "R5 loopback byte", v, b);
      wait_stat(8'h7F, 8'h03, ok);
      chk(ok, "R4 R5 idle after byte", ok, 1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule